// File: doc/BRIEF.md
# Aligned Neighbor-List Fetch Sequencer

This block turns a vertex number into a stream of warp-wide fetch beats over a compressed sparse-row edge list. It keeps a small local table of list offsets, indexed by vertex. The entry for vertex v holds the first element of that vertex's neighbor list, and the entry for v+1 holds the element just past its end. Once a vertex is accepted, the block reads both entries. It then walks the list in 32-element steps, and one 32-lane group serves the whole list.

The walk starts at the true start index rounded down to a 128-byte line boundary, so every beat begins on a line. Each lane of a beat is enabled only if its element lies inside the list. The element size is a build parameter of 4 or 8 bytes. An upstream scheduler loads the offset table through a write port. It then hands in one vertex at a time, and a downstream fetch engine drains the beats under valid/ready flow control.

Top module: `nlf_fetch_seq`

## Requirements
- R1: After reset, vtx_ready is 1 and beat_valid and done are 0.
- R2: The bounds of vertex v are table entry v (start, inclusive) and table entry v+1 (end, exclusive). Entry i is written by ofs_wr_en with ofs_wr_addr = i.
- R3: The first beat's base is the start index with its low 4 bits cleared when ELEM_BYTES is 8, or with its low 5 bits cleared when ELEM_BYTES is 4. Every beat base keeps those bits at zero.
- R4: Each accepted beat is followed by a beat whose base is 32 higher. Beats continue while the base is below the end index.
- R5: Bit k of beat_mask refers to element base+k. It is 1 exactly when start <= base+k < end, so every beat enables at least one lane.
- R6: beat_last is 1 on the final beat of a vertex (base+32 >= end) and 0 on every other beat.
- R7: A vertex whose end index is not above its start index produces no beats. Its done pulse comes 3 clock edges after the accepting edge.
- R8: While beat_valid is 1 and beat_ready is 0, the beat is held unchanged and no beat is lost.
- R9: A vertex is accepted only while vtx_ready is 1, which means the block is idle. vtx_valid and vtx_id are ignored while the block is busy.
- R10: done pulses high for exactly one cycle, in the cycle after the handshake of the final beat.
- R11: The offset table has one cycle of read latency. The first beat of a non-empty list is valid from the third edge after acceptance, and beat_valid stays 0 before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ofs_wr_en | input | 1 | Offset table write strobe |
| ofs_wr_addr | input | $clog2(NUM_VERT+1) | Offset table write index |
| ofs_wr_data | input | IDX_W | Offset value to write |
| vtx_valid | input | 1 | Vertex request valid |
| vtx_id | input | $clog2(NUM_VERT) | Vertex number |
| vtx_ready | output | 1 | Block idle, able to accept a vertex |
| beat_valid | output | 1 | Fetch beat valid |
| beat_ready | input | 1 | Downstream accepts the beat |
| beat_base | output | IDX_W | Element index of lane 0 |
| beat_mask | output | 32 | Lane enables, bit k for element base+k |
| beat_last | output | 1 | Final beat of the current vertex |
| done | output | 1 | One-cycle pulse when a vertex is finished |

## Verification
Some properties are checked on every cycle by the assertions:
- line alignment of each base;
- the 32-element step between accepted beats;
- a non-zero lane mask;
- a held beat under stall;
- a single-cycle done that follows the last handshake;
- the drop of vtx_ready on acceptance.

Other properties only the bench's sweeps can show. These are the exact bounds taken from entries v and v+1, the exact lane mask at both edges of a list, the beat count, and the fixed latency to the first beat or to done. The sweeps run every vertex of a table with empty, short, misaligned and multi-beat lists, under both element sizes and a rotating stall pattern.

// File: rtl/nlf_pkg.sv
package nlf_pkg;
  localparam int unsigned LANES      = 32;
  localparam int unsigned LINE_BYTES = 128;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_LO  = 3'd1,
    ST_RD_HI  = 3'd2,
    ST_EVAL   = 3'd3,
    ST_STREAM = 3'd4
  } nlf_state_e;
endpackage

// File: rtl/nlf_offset_ram.sv
module nlf_offset_ram #(
  parameter int unsigned DEPTH = 65,
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (32'(wr_addr) < DEPTH)) mem_q[wr_addr] <= wr_data;
    if (rd_en) rd_data <= (32'(rd_addr) < DEPTH) ? mem_q[rd_addr] : '0;
  end
endmodule

// File: rtl/nlf_lane_mask.sv
module nlf_lane_mask #(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned LANES = 32
) (
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] lo,
  input  logic [IDX_W-1:0] hi,
  output logic [LANES-1:0] mask,
  output logic             last
);
  localparam int unsigned XW = IDX_W + 1;

  function automatic logic lane_on(input logic [IDX_W-1:0] b, input int unsigned k,
                                   input logic [IDX_W-1:0] l, input logic [IDX_W-1:0] h);
    logic [XW-1:0] idx;
    idx = {1'b0, b} + XW'(k);
    return (idx >= {1'b0, l}) && (idx < {1'b0, h});
  endfunction

  function automatic logic is_final(input logic [IDX_W-1:0] b, input logic [IDX_W-1:0] h);
    return ({1'b0, b} + XW'(LANES)) >= {1'b0, h};
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mask[k] = lane_on(base, k, lo, hi);
  end

  assign last = is_final(base, hi);
endmodule

// File: rtl/nlf_ctrl.sv
module nlf_ctrl
  import nlf_pkg::*;
#(
  parameter int unsigned VID_W      = 6,
  parameter int unsigned AW         = 7,
  parameter int unsigned IDX_W      = 16,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vtx_valid,
  input  logic [VID_W-1:0] vtx_id,
  output logic             vtx_ready,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [IDX_W-1:0] rd_data,
  output logic             beat_valid,
  input  logic             beat_ready,
  input  logic             beat_last,
  output logic [IDX_W-1:0] base_q,
  output logic [IDX_W-1:0] start_q,
  output logic [IDX_W-1:0] end_q,
  output logic             done
);
  nlf_state_e       state_q;
  logic [VID_W-1:0] vid_q;

  function automatic logic [IDX_W-1:0] align_down(input logic [IDX_W-1:0] idx);
    return {idx[IDX_W-1:ALIGN_BITS], ALIGN_BITS'(0)};
  endfunction

  // named internal events
  logic accept, beat_fire, list_empty;
  assign accept     = vtx_valid && vtx_ready;
  assign beat_fire  = beat_valid && beat_ready;
  assign list_empty = (rd_data <= start_q);

  assign vtx_ready  = (state_q == ST_IDLE);
  assign beat_valid = (state_q == ST_STREAM);
  assign rd_en      = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign rd_addr    = (state_q == ST_RD_HI) ? AW'(vid_q) + AW'(1) : AW'(vid_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vid_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      base_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          vid_q   <= vtx_id;
          state_q <= ST_RD_LO;
        end
        ST_RD_LO: state_q <= ST_RD_HI;
        ST_RD_HI: begin
          start_q <= rd_data;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          end_q  <= rd_data;
          base_q <= align_down(start_q);
          if (list_empty) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_STREAM;
          end
        end
        ST_STREAM: if (beat_fire) begin
          if (beat_last) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            base_q <= base_q + IDX_W'(LANES);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !vtx_ready && !beat_valid);
  // R4
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> beat_valid && (base_q == $past(base_q) + IDX_W'(LANES)));
  // R6
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && beat_last |=> !beat_valid && done);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/nlf_fetch_seq.sv
module nlf_fetch_seq
  import nlf_pkg::*;
#(
  parameter int unsigned ELEM_BYTES = 8,
  parameter int unsigned NUM_VERT   = 64,
  parameter int unsigned IDX_W      = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ofs_wr_en,
  input  logic [$clog2(NUM_VERT+1)-1:0]  ofs_wr_addr,
  input  logic [IDX_W-1:0]               ofs_wr_data,
  input  logic                           vtx_valid,
  input  logic [$clog2(NUM_VERT)-1:0]    vtx_id,
  output logic                           vtx_ready,
  output logic                           beat_valid,
  input  logic                           beat_ready,
  output logic [IDX_W-1:0]               beat_base,
  output logic [31:0]                    beat_mask,
  output logic                           beat_last,
  output logic                           done
);
  localparam int unsigned DEPTH          = NUM_VERT + 1;
  localparam int unsigned AW             = $clog2(NUM_VERT + 1);
  localparam int unsigned VID_W          = $clog2(NUM_VERT);
  localparam int unsigned EB             = (ELEM_BYTES == 4) ? 4 : 8;
  localparam int unsigned ELEMS_PER_LINE = LINE_BYTES / EB;
  localparam int unsigned ALIGN_BITS     = $clog2(ELEMS_PER_LINE);

  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic [IDX_W-1:0] rd_data;
  logic [IDX_W-1:0] start_q, end_q;

  nlf_offset_ram #(.DEPTH(DEPTH), .AW(AW), .DW(IDX_W)) ofs_ram_i (
    .clk     (clk),
    .wr_en   (ofs_wr_en),
    .wr_addr (ofs_wr_addr),
    .wr_data (ofs_wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  nlf_ctrl #(.VID_W(VID_W), .AW(AW), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vtx_valid  (vtx_valid),
    .vtx_id     (vtx_id),
    .vtx_ready  (vtx_ready),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_last  (beat_last),
    .base_q     (beat_base),
    .start_q    (start_q),
    .end_q      (end_q),
    .done       (done)
  );

  nlf_lane_mask #(.IDX_W(IDX_W), .LANES(LANES)) mask_i (
    .base (beat_base),
    .lo   (start_q),
    .hi   (end_q),
    .mask (beat_mask),
    .last (beat_last)
  );

  // R3
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_base[ALIGN_BITS-1:0] == '0));
  // R5
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_mask != '0));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_base)
                                  && $stable(beat_mask) && $stable(beat_last));
endmodule

// File: tb/nlf_fetch_seq_tb.sv
module nlf_fetch_seq_tb_top;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  vv = '0;
  logic [3:0]  vid = '0;
  logic [1:0]  brdy = '0;
  logic [1:0]  vrdy, bv, blast, dn;
  logic [15:0] bbase [2];
  logic [31:0] bmask [2];

  int nchk = 0;
  int nfail = 0;
  int offs [NV+1];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nlf_fetch_seq #(.ELEM_BYTES(8), .NUM_VERT(NV), .IDX_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ofs_wr_en(wr_en), .ofs_wr_addr(wr_addr),
    .ofs_wr_data(wr_data), .vtx_valid(vv[0]), .vtx_id(vid), .vtx_ready(vrdy[0]),
    .beat_valid(bv[0]), .beat_ready(brdy[0]), .beat_base(bbase[0]),
    .beat_mask(bmask[0]), .beat_last(blast[0]), .done(dn[0]));

  nlf_fetch_seq #(.ELEM_BYTES(4), .NUM_VERT(NV), .IDX_W(16)) dut_w4_i (
    .clk(clk), .rst_n(rst_n), .ofs_wr_en(wr_en), .ofs_wr_addr(wr_addr),
    .ofs_wr_data(wr_data), .vtx_valid(vv[1]), .vtx_id(vid), .vtx_ready(vrdy[1]),
    .beat_valid(bv[1]), .beat_ready(brdy[1]), .beat_base(bbase[1]),
    .beat_mask(bmask[1]), .beat_last(blast[1]), .done(dn[1]));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int degree(input int i);
    if (i == 3) return 32;
    if (i == 7) return 1;
    if (i == 9) return 33;
    if (i == 11) return 31;
    if (i % 5 == 0) return 0;
    return (i * 37 + 5) % 75;
  endfunction

  function automatic logic [31:0] exp_mask(input int b, input int s, input int e);
    logic [31:0] m;
    for (int k = 0; k < 32; k++) m[k] = (b + k >= s) && (b + k < e);
    return m;
  endfunction

  task automatic run_vertex(input int s, input int v, input bit poke);
    int st, en, lb, b, cyc;
    st = offs[v];
    en = offs[v+1];
    lb = (s == 0) ? 4 : 5;
    b  = st & ~((1 << lb) - 1);
    cyc = 0;
    @(negedge clk);
    chk("R9 idle ready", 64'(vrdy[s]), 64'd1);
    vid = 4'(v);
    vv[s] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vv[s] = 1'b0;
    for (int w = 0; w < 3; w++) begin
      #1;
      chk("R11 no early beat", 64'(bv[s]), 64'd0);
      chk("R9 busy not ready", 64'(vrdy[s]), 64'd0);
      @(negedge clk);
    end
    if (en <= st) begin
      #1;
      chk("R7 empty done", 64'(dn[s]), 64'd1);
      chk("R7 empty no beat", 64'(bv[s]), 64'd0);
      @(negedge clk);
      #1;
      chk("R10 done single", 64'(dn[s]), 64'd0);
      return;
    end
    while (b < en && cyc < 2000) begin
      brdy[s] = ((cyc + v) % 3) != 0;
      if (poke) begin
        vv[s] = 1'b1;
        vid = 4'((v + 5) % NV);
      end
      #1;
      chk("R4 beat valid", 64'(bv[s]), 64'd1);
      chk("R3 R4 base", 64'(bbase[s]), 64'(b));
      chk("R5 R2 mask", 64'(bmask[s]), 64'(exp_mask(b, st, en)));
      chk("R6 last", 64'(blast[s]), 64'(b + 32 >= en));
      chk("R9 busy ignores vtx", 64'(vrdy[s]), 64'd0);
      @(posedge clk);
      if (brdy[s]) b += 32;
      cyc++;
      @(negedge clk);
    end
    brdy[s] = 1'b0;
    vv[s] = 1'b0;
    #1;
    chk("R10 done after last", 64'(dn[s]), 64'd1);
    chk("R10 beats end", 64'(bv[s]), 64'd0);
    chk("R8 R4 beat count", 64'(b >= en), 64'd1);
    @(negedge clk);
    #1;
    chk("R10 done single", 64'(dn[s]), 64'd0);
  endtask

  initial begin
    offs[0] = 3;
    for (int i = 0; i < NV; i++) offs[i+1] = offs[i] + degree(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int s = 0; s < 2; s++) begin
      chk("R1 reset ready", 64'(vrdy[s]), 64'd1);
      chk("R1 reset beat", 64'(bv[s]), 64'd0);
      chk("R1 reset done", 64'(dn[s]), 64'd0);
    end
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 5'(i);
      wr_data = 16'(offs[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < NV; v++)
        run_vertex(s, v, (v == 4) || (v == 9));
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule